// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block takes supervisory conditions that have already been digitised and turns them into a system reset and a watchdog indication. The conditions are a supply-below-threshold flag, an active-low push-button reset, a watchdog kick line, a watchdog-disable flag and a battery-backup flag. The reset is asserted while any reset cause is present. Once every cause has cleared, the reset is held for a fixed number of timebase ticks. A watchdog counter watches the kick line for edges.

A build-time parameter selects one of two watchdog styles. In pulse style, an expired watchdog starts a full-length reset pulse. A kick line that never moves therefore gives a periodic train of reset pulses. In flag style, an expired watchdog drives a separate active-low output low, and that output stays low until the kick line moves again or a reset occurs.

All long periods are counted in ticks of a shared timebase enable. A real system sets the tick to about one millisecond, while a bench can make every cycle a tick. The push-button input passes through a synchroniser and a debounce filter that is counted in clock cycles.

Top module: `supv_reset_wdog`

## Requirements
- R1: While `supply_low` is 1, `rst_out` is 1 in the same cycle, and it stays 1 on the following cycles.
- R2: After every reset cause has cleared, `rst_out` stays 1 for exactly `RESET_TICKS` ticks and then returns to 0. After power-on with no cause present, `rst_out` falls on the `RESET_TICKS`-th rising clock edge after `rst_n` goes high.
- R3: A `man_rst_n` low level that lasts at least `DEBOUNCE_CYCLES` cycles asserts the reset. With `DEBOUNCE_CYCLES`=4, `rst_out` rises 7 cycles after the input falls. This is 2 synchroniser cycles, 4 filter cycles and 1 timer register. Release of `man_rst_n` is followed by the R2 hold.
- R4: Any change of `kick` restarts the watchdog count. This includes a pulse of a single cycle of either polarity. In flag style, `wd_out_n` returns to 1 within a few cycles of the change.
- R5: In flag style, if `kick` has no edge for `WDOG_TICKS` ticks, `wd_out_n` goes to 0. It stays 0 until the next kick edge or until a reset.
- R6: While `rst_out` is 1, the watchdog count is cleared and `wd_out_n` is driven to 1.
- R7: While `wd_disable` or `backup_mode` is 1, the watchdog count is held at zero and `wd_out_n` is 1.
- R8: A `man_rst_n` low pulse shorter than `DEBOUNCE_CYCLES` cycles has no effect on `rst_out`.
- R9: The reset hold count and the watchdog count advance only in cycles where `tick` is 1. With `tick` at 0, a pending reset hold never ends.
- R10: In pulse style, each expiry gives a `rst_out` pulse lasting `RESET_TICKS` cycles. With every cycle a tick and no kick edges, the pulses repeat with `WDOG_TICKS`+1 low cycles between them. In pulse style, `wd_out_n` stays 1.
- R11: `rst_out_n` is always the inverse of `rst_out`.
- R12: While `rst_n` is 0, `rst_out` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| tick | input | 1 | Timebase enable for the hold and watchdog counters |
| supply_low | input | 1 | Supply below threshold (active high) |
| man_rst_n | input | 1 | Push-button reset, active low, asynchronous |
| kick | input | 1 | Watchdog kick line, asynchronous |
| wd_disable | input | 1 | Kick line undriven: suspend the watchdog |
| backup_mode | input | 1 | Battery-backup mode: suspend the watchdog |
| rst_out | output | 1 | System reset, active high |
| rst_out_n | output | 1 | System reset, active low |
| wd_out_n | output | 1 | Watchdog expired, active low (flag style only) |

## Verification
The bound checker watches the one-cycle cause-and-effect links on every cycle:

- a supply-low or a debounced push-button reset is followed by an asserted reset;
- the reset never releases while a cause is present or on a cycle without a tick;
- a kick edge, a reset, a disable or backup mode leaves the watchdog output high;
- the watchdog output never falls right after a kick edge or a reset.

Some behaviours need counted windows, so only the bench scenarios can show them:

- the exact hold length;
- the debounce latency and the rejection of a short glitch;
- the freeze of the hold while the tick is idle;
- the width and spacing of the repeating reset pulses in pulse style.

// File: rtl/supv_pkg.sv
// Shared type for the supervisory reset and watchdog controller.
// Assumes: nothing; only the watchdog style selector lives here.
package supv_pkg;
    typedef enum logic {
        WD_PULSE = 1'b0,   // expiry starts a reset pulse
        WD_FLAG  = 1'b1    // expiry drives a separate active-low flag
    } wd_style_e;
endpackage

// File: rtl/supv_debounce.sv
// Synchronises an asynchronous active-low level and passes a change only
// after it has been stable for DEBOUNCE_CYCLES clocks.
// Assumes: the released (high) level is the safe state at power-on.
module supv_debounce #(
    parameter int unsigned DEBOUNCE_CYCLES = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_n,
    output logic filt_n
);
    localparam int unsigned CW = $clog2(DEBOUNCE_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(DEBOUNCE_CYCLES - 1);

    logic          sync1, sync2;
    logic [CW-1:0] stable_cnt;

    // Two-flop synchroniser followed by a stability counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1      <= 1'b1;
            sync2      <= 1'b1;
            filt_n     <= 1'b1;
            stable_cnt <= '0;
        end else begin
            sync1 <= raw_n;
            sync2 <= sync1;
            if (sync2 == filt_n) begin
                stable_cnt <= '0;
            end else if (stable_cnt == LAST) begin
                filt_n     <= sync2;
                stable_cnt <= '0;
            end else begin
                stable_cnt <= stable_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/supv_kick_edge.sv
// Synchronises the watchdog kick line and flags any change of level.
// Assumes: a kick level held for one clock is wide enough to be seen.
module supv_kick_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic kick_edge
);
    logic sync1, sync2, prev;

    // Synchroniser plus one history flop for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b0;
            sync2 <= 1'b0;
            prev  <= 1'b0;
        end else begin
            sync1 <= kick;
            sync2 <= sync1;
            prev  <= sync2;
        end
    end

    assign kick_edge = sync2 ^ prev;
endmodule

// File: rtl/supv_reset_timer.sv
// Holds the reset active while a cause is present and for HOLD_TICKS
// ticks afterwards; starts active out of power-on reset.
// Assumes: cause is synchronous to clk.
module supv_reset_timer #(
    parameter int unsigned HOLD_TICKS = 215
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic cause,
    output logic active
);
    localparam int unsigned CW = $clog2(HOLD_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    logic [CW-1:0] hold_cnt;

    // Restart on any cause, count ticks once the causes have gone.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b1;
            hold_cnt <= '0;
        end else if (cause) begin
            active   <= 1'b1;
            hold_cnt <= '0;
        end else if (active && tick) begin
            if (hold_cnt == LAST) begin
                active   <= 1'b0;
                hold_cnt <= '0;
            end else begin
                hold_cnt <= hold_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/supv_wdog_timer.sv
// Counts ticks since the last kick edge; on expiry either issues a
// one-cycle reset request (pulse style) or sets a flag (flag style).
// Assumes: rst_active, kick_edge and suspend are synchronous to clk.
module supv_wdog_timer
    import supv_pkg::*;
#(
    parameter int unsigned WDOG_TICKS = 1235,
    parameter wd_style_e   WD_STYLE   = WD_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic kick_edge,
    input  logic rst_active,
    input  logic suspend,
    output logic rst_req,
    output logic expired
);
    localparam int unsigned CW = $clog2(WDOG_TICKS + 1);
    localparam logic [CW-1:0] LAST = CW'(WDOG_TICKS - 1);

    logic [CW-1:0] wd_cnt;
    logic          clear;
    logic          expire;

    assign clear  = kick_edge | rst_active | suspend;
    assign expire = tick && (wd_cnt == LAST) && !clear;

    // Tick counter, restarted by clears and by its own expiry.
    always_ff @(posedge clk) begin
        if (!rst_n)              wd_cnt <= '0;
        else if (clear || expire) wd_cnt <= '0;
        else if (tick)           wd_cnt <= wd_cnt + 1'b1;
    end

    generate
        if (WD_STYLE == WD_PULSE) begin : g_pulse
            logic req_q;
            // One-cycle reset request per expiry.
            always_ff @(posedge clk) begin
                if (!rst_n) req_q <= 1'b0;
                else        req_q <= expire;
            end
            assign rst_req = req_q;
            assign expired = 1'b0;
        end else begin : g_flag
            logic flag_q;
            // Sticky expiry flag, dropped by any clear condition.
            always_ff @(posedge clk) begin
                if (!rst_n)      flag_q <= 1'b0;
                else if (clear)  flag_q <= 1'b0;
                else if (expire) flag_q <= 1'b1;
            end
            assign rst_req = 1'b0;
            assign expired = flag_q;
        end
    endgenerate
endmodule

// File: rtl/supv_reset_wdog.sv
// Top of the supervisory reset and watchdog controller: debounces the
// push-button, detects kick edges and combines reset causes.
// Assumes: supply_low, wd_disable, backup_mode and tick are synchronous.
module supv_reset_wdog
    import supv_pkg::*;
#(
    parameter int unsigned RESET_TICKS     = 215,
    parameter int unsigned WDOG_TICKS      = 1235,
    parameter int unsigned DEBOUNCE_CYCLES = 5,
    parameter wd_style_e   WD_STYLE        = WD_PULSE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic supply_low,
    input  logic man_rst_n,
    input  logic kick,
    input  logic wd_disable,
    input  logic backup_mode,
    output logic rst_out,
    output logic rst_out_n,
    output logic wd_out_n
);
    logic mr_filt_n;
    logic kick_edge;
    logic wd_rst_req;
    logic wd_expired;
    logic hold_active;
    logic reset_cause;

    supv_debounce #(.DEBOUNCE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_n  (man_rst_n),
        .filt_n (mr_filt_n)
    );

    supv_kick_edge u_kick (
        .clk       (clk),
        .rst_n     (rst_n),
        .kick      (kick),
        .kick_edge (kick_edge)
    );

    assign reset_cause = supply_low | ~mr_filt_n | wd_rst_req;

    supv_reset_timer #(.HOLD_TICKS(RESET_TICKS)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cause  (reset_cause),
        .active (hold_active)
    );

    assign rst_out   = supply_low | hold_active;
    assign rst_out_n = ~rst_out;

    supv_wdog_timer #(.WDOG_TICKS(WDOG_TICKS), .WD_STYLE(WD_STYLE)) u_wd (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .kick_edge  (kick_edge),
        .rst_active (rst_out),
        .suspend    (wd_disable | backup_mode),
        .rst_req    (wd_rst_req),
        .expired    (wd_expired)
    );

    assign wd_out_n = ~wd_expired;
endmodule

// File: rtl/supv_reset_wdog_chk.sv
// Assertion checker for supv_reset_wdog, attached with bind below.
// Assumes: observes ports plus the debounced button and kick-edge nets.
module supv_reset_wdog_chk
    import supv_pkg::*;
#(
    parameter wd_style_e WD_STYLE = WD_PULSE
) (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic supply_low,
    input logic wd_disable,
    input logic backup_mode,
    input logic rst_out,
    input logic wd_out_n,
    input logic mr_filt_n,
    input logic kick_edge
);
    AST_SUPPLY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> rst_out);                                            // R1
    AST_BUTTON_RESETS: assert property (@(posedge clk) disable iff (!rst_n)
        !mr_filt_n |=> rst_out);                                            // R3
    AST_NO_EARLY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (!$past(supply_low) && $past(mr_filt_n)));        // R2
    AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> $past(tick));                                    // R9
    AST_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick_edge |=> wd_out_n);                                            // R4
    AST_EXPIRY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wd_out_n) |-> (!$past(kick_edge) && !$past(rst_out)));         // R5
    AST_RESET_CLEARS_WD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out |=> wd_out_n);                                              // R6
    AST_SUSPEND_WD: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_disable || backup_mode) |=> wd_out_n);                          // R7
    AST_PULSE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (WD_STYLE == WD_PULSE) |-> wd_out_n);                               // R10
endmodule

bind supv_reset_wdog supv_reset_wdog_chk #(.WD_STYLE(WD_STYLE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .supply_low  (supply_low),
    .wd_disable  (wd_disable),
    .backup_mode (backup_mode),
    .rst_out     (rst_out),
    .wd_out_n    (wd_out_n),
    .mr_filt_n   (mr_filt_n),
    .kick_edge   (kick_edge)
);

// File: tb/sim_supv_reset_wdog.sv
// Bench: flag-style instance u0 and pulse-style instance u1 share inputs.
module sim_supv_reset_wdog;
    import supv_pkg::*;

    localparam int unsigned RT  = 8;
    localparam int unsigned WT  = 12;
    localparam int unsigned DB  = 4;
    localparam int          NV  = 12;
    localparam int          WATCHDOG_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b1;
    logic supply_low = 1'b0;
    logic man_rst_n = 1'b1;
    logic kick = 1'b0;
    logic wd_disable = 1'b0;
    logic backup_mode = 1'b0;
    logic r0, r0n, w0n, r1, r1n, w1n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #10 clk = ~clk;   // 50 MHz

    supv_reset_wdog #(.RESET_TICKS(RT), .WDOG_TICKS(WT), .DEBOUNCE_CYCLES(DB),
                      .WD_STYLE(WD_FLAG)) u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
        .man_rst_n(man_rst_n), .kick(kick), .wd_disable(wd_disable),
        .backup_mode(backup_mode), .rst_out(r0), .rst_out_n(r0n), .wd_out_n(w0n));

    supv_reset_wdog #(.RESET_TICKS(RT), .WDOG_TICKS(WT), .DEBOUNCE_CYCLES(DB),
                      .WD_STYLE(WD_PULSE)) u1 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .supply_low(supply_low),
        .man_rst_n(man_rst_n), .kick(kick), .wd_disable(wd_disable),
        .backup_mode(backup_mode), .rst_out(r1), .rst_out_n(r1n), .wd_out_n(w1n));

    // Vector fields: [15] supply_low, [14] man_rst_n, [13] toggle kick every
    // 4 cycles, [12] wd_disable, [11] backup_mode, [10:4] cycles to wait,
    // [3] expected rst_out, [2] expected wd_out_n, [1:0] unused.
    localparam logic [15:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd30, 1'b0, 1'b1, 2'b00},
        {1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 7'd3,  1'b1, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd4,  1'b1, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd10, 1'b0, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd30, 1'b0, 1'b0, 2'b00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd6,  1'b0, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 7'd30, 1'b0, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 7'd30, 1'b0, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd30, 1'b0, 1'b0, 2'b00},
        {1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'd10, 1'b1, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 7'd6,  1'b1, 1'b1, 2'b00},
        {1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 7'd20, 1'b0, 1'b1, 2'b00}
    };
    string tags [NV] = '{"R4", "R1", "R2", "R2", "R5", "R4",
                         "R7", "R7", "R5", "R6", "R3", "R3"};

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Cycle counter and hang watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles == WATCHDOG_LIMIT) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int hi_cnt;
        int lo_cnt;
        int guard;

        // R12: reset output asserted during power-on reset.
        cyc(3);
        chk("R12", r0, 1'b1);
        chk("R11", r0n, 1'b0);
        // R2: exact power-on hold of RT edges.
        rst_n = 1'b1;
        cyc(RT - 1);
        chk("R2", r0, 1'b1);
        cyc(1);
        chk("R2", r0, 1'b0);
        chk("R11", r0n, 1'b1);

        // Vector table walk on the flag-style instance.
        for (int v = 0; v < NV; v++) begin
            supply_low  = VEC[v][15];
            man_rst_n   = VEC[v][14];
            wd_disable  = VEC[v][12];
            backup_mode = VEC[v][11];
            for (int i = 0; i < int'(VEC[v][10:4]); i++) begin
                if (VEC[v][13] && (i % 4 == 0)) kick = ~kick;
                cyc(1);
            end
            chk(tags[v], r0, VEC[v][3]);
            chk(tags[v], w0n, VEC[v][2]);
            chk("R11", r0n, ~VEC[v][3]);
        end

        // R4: single-cycle kick pulse counts as an edge.
        cyc(20);
        chk("R5", w0n, 1'b0);
        kick = ~kick;
        cyc(1);
        kick = ~kick;
        cyc(5);
        chk("R4", w0n, 1'b1);

        // R8: short push-button glitch ignored.
        man_rst_n = 1'b0;
        cyc(DB - 2);
        man_rst_n = 1'b1;
        hi_cnt = 0;
        for (int i = 0; i < 15; i++) begin
            cyc(1);
            if (r0) hi_cnt++;
        end
        chk("R8", hi_cnt != 0, 1'b0);

        // R3: exact debounce latency of 7 cycles.
        man_rst_n = 1'b0;
        cyc(6);
        chk("R3", r0, 1'b0);
        cyc(1);
        chk("R3", r0, 1'b1);
        man_rst_n = 1'b1;
        cyc(20);
        chk("R3", r0, 1'b0);

        // R9: hold freezes while tick is idle.
        tick = 1'b0;
        supply_low = 1'b1;
        cyc(1);
        chk("R1", r0, 1'b1);
        cyc(1);
        supply_low = 1'b0;
        cyc(30);
        chk("R9", r0, 1'b1);
        tick = 1'b1;
        cyc(RT - 1);
        chk("R9", r0, 1'b1);
        cyc(1);
        chk("R9", r0, 1'b0);

        // R10: pulse style repeats full-length reset pulses.
        guard = 0;
        while (r1 && guard < 200) begin cyc(1); guard++; end
        while (!r1 && guard < 200) begin cyc(1); guard++; end
        hi_cnt = 0;
        while (r1 && hi_cnt < 200) begin
            chk("R10", w1n, 1'b1);
            cyc(1);
            hi_cnt++;
        end
        lo_cnt = 0;
        while (!r1 && lo_cnt < 200) begin cyc(1); lo_cnt++; end
        checks++;
        if (hi_cnt != int'(RT)) begin
            fails++;
            $display("FAIL R10: pulse width actual %0d expected %0d", hi_cnt, RT);
        end
        checks++;
        if (lo_cnt != int'(WT) + 1) begin
            fails++;
            $display("FAIL R10: gap actual %0d expected %0d", lo_cnt, WT + 1);
        end
        chk("R11", r1n, ~r1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule